// File: doc/BRIEF.md
# Bit-Banged Serial EEPROM Target

This block is a 256-byte serial EEPROM target on a two-wire bus whose line levels come from software. Each time the host writes a new pair of clock and data levels, it pulses `smp_valid` for one cycle. The block compares that pair with the previous one. From the change it detects bus conditions and clock edges, and it answers on `sda_out`, which the host reads back after the write.

The block has no free-running bus clock and does no oversampling. A bit position counter advances only on accepted rising clock edges:

- Positions 1 to 8 carry the command byte.
- Positions 9 to 16 carry either the word address (write direction) or the data byte being returned (read direction).
- Position 17 is the trailing slot.

A write transaction only sets the address pointer. A later read transaction returns the byte at that address and then streams the following bytes. The storage array is filled through a separate initialisation port and is never written over the bus.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset, and after a reset applied in the middle of a transfer, `sda_out` is 1 and the block is idle, so bits clocked without a START get no acknowledge.
- R2: A START is a sample where SCL is 1 in both the previous and the current sample and SDA goes from 1 to 0. START puts the bit counter at position 1. While idle, every other line activity is ignored and `sda_out` stays 1.
- R3: A bit is taken only at a sample where SCL goes from 0 to 1 and SDA equals its previous sample. A rising SCL with a changed SDA has no effect.
- R4: The command byte is shifted in MSB first over 8 rising edges. At the 9th rising edge, `sda_out` is 0 (acknowledge).
- R5: Command bit 0 selects the direction: 1 means read, 0 means write. In write direction the next 8 bits form the word address, MSB first, and the following rising edge gets an acknowledge of 0.
- R6: In read direction, the 8 rising edges after the command acknowledge put the stored byte on `sda_out`, MSB first. That byte is loaded from storage at the address set by the last write transaction, at the moment that address was completed.
- R7: After each read byte, one further rising edge (the master's acknowledge slot) leads straight into the next byte. That byte comes from the address plus one, and the address wraps from 255 to 0.
- R8: `sda_out` is 1 on every sample that does not drive an acknowledge or a read data bit, including all samples during address bits. Between samples it holds its value.
- R9: An `init_we` pulse writes `init_data` into storage at `init_addr`, and a later read returns the new value.
- R10: A STOP (SCL 1 in both samples and SDA going from 0 to 1) returns the block to idle from any position. The bits that follow get no acknowledge until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | One-cycle strobe: a new line sample is presented |
| smp_scl | input | 1 | Sampled clock line level |
| smp_sda | input | 1 | Sampled data line level from the master |
| init_we | input | 1 | Storage initialisation write enable |
| init_addr | input | AW (8) | Storage initialisation address |
| init_data | input | 8 | Storage initialisation data |
| sda_out | output | 1 | Data line level driven by the target (1 = released) |

## Verification
The assertions assume that each line sample arrives as a single-cycle `smp_valid` pulse, that between pulses the sample inputs carry no meaning, and that only one line changes from one sample to the next. The bench holds to this by sending every bus action through one task. That task presents a sample for exactly one clock, then drops the strobe. It changes SDA only while SCL is low, except for deliberate START, STOP and changed-data-on-rising-clock samples. Storage is initialised only while no transfer depends on a fetch that is already in flight.

// File: rtl/i2cee_pkg.sv
package i2cee_pkg;
  localparam int BYTE_W   = 8;
  localparam int TICK_W   = 5;
  typedef logic [TICK_W-1:0] tick_t;

  localparam tick_t POS_IDLE     = 5'd0;
  localparam tick_t POS_CMD_LAST = 5'd8;
  localparam tick_t POS_BYTE_1ST = 5'd9;
  localparam tick_t POS_BYTE_END = 5'd16;
  localparam tick_t POS_TAIL     = 5'd17;

  // shift one bus bit into the bottom of a byte, MSB arrives first
  function automatic logic [BYTE_W-1:0] shift_msb_first(
      input logic [BYTE_W-1:0] cur, input logic b);
    return {cur[BYTE_W-2:0], b};
  endfunction

  // bit position that follows an accepted bit
  function automatic tick_t advance(input tick_t t);
    return t + tick_t'(1);
  endfunction
endpackage

// File: rtl/i2cee_lines.sv
module i2cee_lines (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_valid,
  input  logic smp_scl,
  input  logic smp_sda,
  output logic ev_start,
  output logic ev_stop,
  output logic rise_ok,
  output logic rise_chg
);
  logic last_scl, last_sda;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_scl <= 1'b1;
      last_sda <= 1'b1;
    end else if (smp_valid) begin
      last_scl <= smp_scl;
      last_sda <= smp_sda;
    end
  end

  logic hold_high, scl_up, sda_same;
  assign hold_high = last_scl & smp_scl;
  assign scl_up    = ~last_scl & smp_scl;
  assign sda_same  = (last_sda == smp_sda);

  assign ev_start = smp_valid & hold_high &  last_sda & ~smp_sda;
  assign ev_stop  = smp_valid & hold_high & ~last_sda &  smp_sda;
  assign rise_ok  = smp_valid & scl_up &  sda_same;
  assign rise_chg = smp_valid & scl_up & ~sda_same;
endmodule

// File: rtl/i2cee_store.sv
module i2cee_store #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/i2cee_seq.sv
module i2cee_seq
  import i2cee_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic          bit_in,
  input  logic          ev_start,
  input  logic          ev_stop,
  input  logic          rise_ok,
  input  logic [7:0]    fetch_data,
  output logic [AW-1:0] fetch_addr,
  output tick_t         pos,
  output logic          ack_pend,
  output logic          rd_dir,
  output logic          sda_q
);
  logic [AW-1:0]     ptr;
  logic [BYTE_W-1:0] dreg;
  logic [BYTE_W-1:0] ptr_wide;
  logic [AW-1:0]     ptr_shifted;
  logic              idle;

  assign idle        = (pos == POS_IDLE) && !ack_pend;
  assign ptr_wide    = shift_msb_first(BYTE_W'(ptr), bit_in);
  assign ptr_shifted = ptr_wide[AW-1:0];
  assign fetch_addr  = rd_dir ? ptr + AW'(1) : ptr_shifted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos      <= POS_IDLE;
      ack_pend <= 1'b0;
      rd_dir   <= 1'b0;
      ptr      <= '0;
      dreg     <= '0;
      sda_q    <= 1'b1;
    end else if (smp_valid) begin
      sda_q <= 1'b1;
      if (ev_start) begin
        pos      <= advance(POS_IDLE);
        ack_pend <= 1'b0;
      end else if (ev_stop) begin
        pos      <= POS_IDLE;
        ack_pend <= 1'b0;
      end else if (!idle && rise_ok) begin
        if (ack_pend) begin
          sda_q    <= 1'b0;
          ack_pend <= 1'b0;
        end else if (pos <= POS_CMD_LAST) begin
          pos <= advance(pos);
          if (pos == POS_CMD_LAST) begin
            ack_pend <= 1'b1;
            rd_dir   <= bit_in;
          end
        end else if (pos <= POS_BYTE_END) begin
          pos <= advance(pos);
          if (rd_dir) begin
            sda_q <= dreg[BYTE_W-1];
            dreg  <= shift_msb_first(dreg, 1'b0);
          end else begin
            ptr <= ptr_shifted;
          end
          if (pos == POS_BYTE_END) begin
            dreg <= fetch_data;
            if (rd_dir) ptr <= fetch_addr;
            else        ack_pend <= 1'b1;
          end
        end else begin
          if (rd_dir) pos <= POS_BYTE_1ST;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import i2cee_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic          smp_scl,
  input  logic          smp_sda,
  input  logic          init_we,
  input  logic [AW-1:0] init_addr,
  input  logic [7:0]    init_data,
  output logic          sda_out
);
  logic          ev_start, ev_stop, rise_ok, rise_chg;
  logic [AW-1:0] fetch_addr;
  logic [7:0]    fetch_data;
  tick_t         pos;
  logic          ack_pend, rd_dir;

  i2cee_lines u_lines (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_valid(smp_valid),
    .smp_scl  (smp_scl),
    .smp_sda  (smp_sda),
    .ev_start (ev_start),
    .ev_stop  (ev_stop),
    .rise_ok  (rise_ok),
    .rise_chg (rise_chg)
  );

  i2cee_store #(.AW(AW)) u_store (
    .clk    (clk),
    .wr_en  (init_we),
    .wr_addr(init_addr),
    .wr_data(init_data),
    .rd_addr(fetch_addr),
    .rd_data(fetch_data)
  );

  i2cee_seq #(.AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .bit_in    (smp_sda),
    .ev_start  (ev_start),
    .ev_stop   (ev_stop),
    .rise_ok   (rise_ok),
    .fetch_data(fetch_data),
    .fetch_addr(fetch_addr),
    .pos       (pos),
    .ack_pend  (ack_pend),
    .rd_dir    (rd_dir),
    .sda_q     (sda_out)
  );
endmodule

// File: rtl/i2cee_chk.sv
module i2cee_chk
  import i2cee_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  smp_valid,
  input logic  ev_start,
  input logic  ev_stop,
  input logic  rise_ok,
  input logic  rise_chg,
  input tick_t pos,
  input logic  ack_pend,
  input logic  rd_dir,
  input logic  sda_out
);
  a_r2_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (pos == 5'd1) && !ack_pend);

  a_r2_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && pos == 5'd0 && !ack_pend && !ev_start) |=> (pos == 5'd0) && sda_out);

  a_r10_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> (pos == 5'd0) && !ack_pend && sda_out);

  a_r3_changed_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise_chg |=> $stable(pos) && $stable(ack_pend) && sda_out);

  a_r4_ack_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_ok && ack_pend && pos != 5'd0) |=> !sda_out && !ack_pend);

  a_r7_stream_next: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_ok && rd_dir && pos == 5'd17) |=> (pos == 5'd9));

  a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(sda_out));

  a_r1_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= 5'd17);
endmodule

bind i2c_eeprom_target i2cee_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .smp_valid(smp_valid),
  .ev_start (ev_start),
  .ev_stop  (ev_stop),
  .rise_ok  (rise_ok),
  .rise_chg (rise_chg),
  .pos      (pos),
  .ack_pend (ack_pend),
  .rd_dir   (rd_dir),
  .sda_out  (sda_out)
);

// File: tb/sim_i2c_eeprom_target.sv
`timescale 1ns/1ps
module sim_i2c_eeprom_target;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_valid = 1'b0, smp_scl = 1'b1, smp_sda = 1'b1;
  logic       init_we = 1'b0;
  logic [7:0] init_addr = '0, init_data = '0;
  logic       sda_out;
  int         total = 0, bad = 0;
  bit         finished = 1'b0;
  logic [7:0] model [256];

  always #2.5 clk = ~clk;

  i2c_eeprom_target u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_scl(smp_scl),
    .smp_sda(smp_sda), .init_we(init_we), .init_addr(init_addr),
    .init_data(init_data), .sda_out(sda_out)
  );

  // {start address, byte count} for random reads
  localparam logic [15:0] VEC [6] = '{16'h0002, 16'h1003, 16'hFE03,
                                      16'h8001, 16'h7F02, 16'h3304};

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 90) ^ ((a % 8) * 32));
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic put(input logic c, input logic d);
    @(negedge clk);
    smp_scl = c; smp_sda = d; smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic send_bit(input logic b, output logic so);
    put(1'b0, b); put(1'b1, b); so = sda_out; put(1'b0, b);
  endtask

  task automatic do_start();
    put(1'b0, 1'b1); put(1'b1, 1'b1); put(1'b1, 1'b0); put(1'b0, 1'b0);
  endtask

  task automatic do_stop();
    put(1'b0, 1'b0); put(1'b1, 1'b0); put(1'b1, 1'b1);
  endtask

  // eight bits then the acknowledge slot; ack = sda_out seen in that slot
  task automatic send_byte(input logic [7:0] v, output logic ack, output logic hi);
    logic so;
    hi = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      send_bit(v[i], so);
      hi = hi & so;
    end
    send_bit(1'b1, ack);
  endtask

  task automatic read_txn(input logic [7:0] a, input int n);
    logic ack, hi, so;
    logic [7:0] got;
    do_start();
    send_byte(8'hA0, ack, hi); check("R4 write command ack", {7'd0, ack}, 8'd0);
    send_byte(a, ack, hi);     check("R5 address ack", {7'd0, ack}, 8'd0);
    check("R8 released during address bits", {7'd0, hi}, 8'd1);
    do_start();
    send_byte(8'hA1, ack, hi); check("R4 read command ack", {7'd0, ack}, 8'd0);
    for (int k = 0; k < n; k++) begin
      got = '0;
      for (int b = 0; b < 8; b++) begin
        send_bit(1'b1, so);
        got = {got[6:0], so};
      end
      if (k == 0) check("R6 first read byte", got, model[8'(a)]);
      else        check("R7 streamed byte", got, model[8'(int'(a) + k)]);
      send_bit(k == n - 1, so);
    end
    do_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic ack, hi, so;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 sda_out after reset", {7'd0, sda_out}, 8'd1);

    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      init_we = 1'b1; init_addr = 8'(a); init_data = pat(a); model[a] = pat(a);
    end
    @(negedge clk); init_we = 1'b0;

    // R2: no START, nothing is acknowledged
    send_byte(8'hA0, ack, hi);
    check("R2 idle ignores bits", {7'd0, ack}, 8'd1);

    for (int v = 0; v < 6; v++) read_txn(VEC[v][15:8], int'(VEC[v][7:0]));

    // R3: a rising clock with changed data must not count as a bit
    do_start();
    put(1'b1, 1'b1); put(1'b0, 1'b1);
    send_byte(8'hA0, ack, hi);
    check("R3 changed-data rise ignored", {7'd0, ack}, 8'd0);
    do_stop();

    // R10: STOP mid-command, then bits without START get no ack
    do_start();
    for (int i = 0; i < 3; i++) send_bit(1'b1, so);
    do_stop();
    send_byte(8'hA0, ack, hi);
    check("R10 after stop no ack", {7'd0, ack}, 8'd1);
    check("R10 sda released", {7'd0, hi}, 8'd1);

    // R9: storage rewrite through the init port
    @(negedge clk); init_we = 1'b1; init_addr = 8'h42; init_data = 8'hC3; model[8'h42] = 8'hC3;
    @(negedge clk); init_we = 1'b0;
    read_txn(8'h42, 1);

    // R1: reset in the middle of a transfer
    do_start();
    for (int i = 0; i < 4; i++) send_bit(1'b0, so);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R1 sda_out after mid-transfer reset", {7'd0, sda_out}, 8'd1);
    send_byte(8'hA0, ack, hi);
    check("R1 idle after mid-transfer reset", {7'd0, ack}, 8'd1);

    // R8: released after a falling-clock sample in read direction
    read_txn(8'hFF, 2);
    put(1'b0, 1'b1);
    check("R8 released on plain sample", {7'd0, sda_out}, 8'd1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule